// File: doc/BRIEF.md
# Self-Timed SAR Bit-Capture Register

This block is the decision logic of a 10-bit charge-domain successive-approximation converter. A dynamic comparator reports each decision as a return-to-zero pulse on one of two lines: the positive line or the negative line. The block captures each decision in its own stage. A stage listens only once the stage above it has decided. As soon as it captures, it drives the matching DAC switch-control pair, and the next bit cycle then uses that charge-reference polarity. The comparator, the DAC and the offset-trim charge pump are outside the block.

No bit counter or sequencer state exists. The chain of stages is the sequencer. A stage freezes after its single capture, and a decision event moves the arming on by one stage. In this register-transfer model, `clk` samples the comparator lines so that rising edges can be seen. It counts nothing and sets no bit timing: a decision happens whenever a comparator line rises. When the LSB stage has decided, the result is ready. One further stage is armed after the LSB when calibration is enabled. It takes the comparison made with the summing nodes shorted and turns it into a single-cycle up or down pulse for the charge pump.

Top module: `sar_bit_capture`

## Requirements
- R1: The block has 10 data stages, with `result[9]` the MSB. Each stage holds a positive and a negative flop, and at most one of the two is ever set. A result bit is 1 when its stage took a positive decision.
- R2: A decision event is a cycle in which a comparator line is high and was low in the previous cycle. An armed stage captures the first event it sees: it records 1 if `cmp_p` is high, otherwise 0. After that the stage ignores all events until the next `start`.
- R3: Exactly one stage is armed at any time until the LSB has decided. The MSB stage is armed after a clear, and stage k is armed only when stage k+1 has decided and stage k has not. Events are therefore taken MSB first.
- R4: `sw_p[k]` and `sw_n[k]` show the positive and negative flops of stage k. They change in the cycle that follows the capturing clock edge, and both are 0 while the stage is undecided.
- R5: `data_ready` goes high in the cycle after the LSB capture edge.
- R6: If `cal_en` is high once the LSB has decided, the extra stage captures the next event and gives one one-cycle pulse. A positive decision gives `trim_dn`; a negative decision gives `trim_up`. Further events give no more pulses until `start`.
- R7: If `cal_en` is low, the extra stage stays disarmed and neither trim output pulses.
- R8: `start` (or `rst`) clears every stage, `data_ready` and `dual_err`, and re-arms the MSB stage. An event in the same cycle as `start` is discarded.
- R9: An event taken by an armed stage while both comparator lines are high sets the sticky `dual_err` and is recorded as positive.
- R10: While `data_ready` is high, `result` stays fixed. Events that arrive when no stage is armed change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock used to detect comparator edges |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion start: clears the stages and re-arms the MSB |
| cmp_p | input | 1 | Positive comparator line (return-to-zero) |
| cmp_n | input | 1 | Negative comparator line (return-to-zero) |
| cal_en | input | 1 | Enables the offset-calibration stage |
| sw_p | output | 10 | Positive switch control for each bit |
| sw_n | output | 10 | Negative switch control for each bit |
| result | output | 10 | Converted code, MSB first |
| data_ready | output | 1 | LSB stage has decided |
| trim_up | output | 1 | One-cycle pulse that raises the offset trim |
| trim_dn | output | 1 | One-cycle pulse that lowers the offset trim |
| dual_err | output | 1 | Sticky flag: both comparator lines were high at a taken event |

## Verification
A wrong arming chain shows up at the switch outputs in the very next cycle, as a bit decided out of order or two bits taken from one event. A stage that fails to freeze shows up as a `result` bit changing when a later pulse arrives. The bench keeps a behavioural model that counts decided bits. It compares every output on every cycle, so any such divergence is reported in the cycle after the edge that caused it. The calibration polarity and its gating are visible at the trim outputs, one cycle after the pulse that follows the LSB.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic {
        DEC_NEG = 1'b0,
        DEC_POS = 1'b1
    } dec_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } pair_t;

    typedef struct packed {
        logic fire;
        dec_e dec;
        logic dual;
    } cmp_evt_t;

    localparam pair_t PAIR_EMPTY = '{pos: 1'b0, neg: 1'b0};

    function automatic pair_t pair_of(input dec_e d);
        pair_t p;
        p.pos = (d == DEC_POS);
        p.neg = (d == DEC_NEG);
        return p;
    endfunction

endpackage

// File: rtl/sar_evt_detect.sv
module sar_evt_detect
    import sar_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmp_p,
    input  logic     cmp_n,
    output cmp_evt_t evt
);
    logic prev_p;
    logic prev_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_p <= 1'b0;
            prev_n <= 1'b0;
        end else begin
            prev_p <= cmp_p;
            prev_n <= cmp_n;
        end
    end

    logic rise_p;
    logic rise_n;

    always_comb begin
        rise_p   = cmp_p & ~prev_p;
        rise_n   = cmp_n & ~prev_n;
        evt.fire = rise_p | rise_n;
        evt.dec  = cmp_p ? DEC_POS : DEC_NEG;
        evt.dual = cmp_p & cmp_n;
    end

endmodule

// File: rtl/sar_bit_stage.sv
module sar_bit_stage
    import sar_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     arm,
    input  cmp_evt_t evt,
    output pair_t    q,
    output logic     decided
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= PAIR_EMPTY;
        end else if (arm && evt.fire && !decided) begin
            q <= pair_of(evt.dec);
        end
    end

    assign decided = q.pos | q.neg;

    assert_pair_excl_R1: assert property (@(posedge clk) disable iff (rst)
        !(q.pos && q.neg));

    assert_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (decided && !clr) |=> $stable(q));

endmodule

// File: rtl/sar_cal_stage.sv
module sar_cal_stage
    import sar_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     arm,
    input  cmp_evt_t evt,
    output logic     trim_up,
    output logic     trim_dn,
    output logic     done
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            done    <= 1'b0;
            trim_up <= 1'b0;
            trim_dn <= 1'b0;
        end else if (arm && evt.fire && !done) begin
            done    <= 1'b1;
            trim_up <= (evt.dec == DEC_NEG);
            trim_dn <= (evt.dec == DEC_POS);
        end else begin
            trim_up <= 1'b0;
            trim_dn <= 1'b0;
        end
    end

    assert_trim_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(trim_up && trim_dn));

    assert_trim_gated_R7: assert property (@(posedge clk) disable iff (rst)
        (trim_up || trim_dn) |-> ($past(arm) && $past(evt.fire)));

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        (trim_up || trim_dn) |=> !(trim_up || trim_dn));

endmodule

// File: rtl/sar_bit_capture.sv
module sar_bit_capture
    import sar_pkg::*;
#(
    parameter int NBITS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cmp_p,
    input  logic             cmp_n,
    input  logic             cal_en,
    output logic [NBITS-1:0] sw_p,
    output logic [NBITS-1:0] sw_n,
    output logic [NBITS-1:0] result,
    output logic             data_ready,
    output logic             trim_up,
    output logic             trim_dn,
    output logic             dual_err
);
    localparam int MSB = NBITS - 1;

    cmp_evt_t         evt;
    pair_t            q       [NBITS];
    logic [NBITS-1:0] decided;
    logic [NBITS-1:0] arm;
    logic             cal_arm;
    logic             cal_done;

    sar_evt_detect u_evt (
        .clk   (clk),
        .rst   (rst),
        .cmp_p (cmp_p),
        .cmp_n (cmp_n),
        .evt   (evt)
    );

    for (genvar k = 0; k < NBITS; k++) begin : g_stage
        if (k == MSB) begin : g_head
            assign arm[k] = ~decided[k];
        end else begin : g_chain
            assign arm[k] = decided[k+1] & ~decided[k];
        end

        sar_bit_stage u_stage (
            .clk     (clk),
            .rst     (rst),
            .clr     (start),
            .arm     (arm[k]),
            .evt     (evt),
            .q       (q[k]),
            .decided (decided[k])
        );

        assign sw_p[k] = q[k].pos;
        assign sw_n[k] = q[k].neg;
    end

    assign cal_arm = decided[0] & cal_en & ~cal_done;

    sar_cal_stage u_cal (
        .clk     (clk),
        .rst     (rst),
        .clr     (start),
        .arm     (cal_arm),
        .evt     (evt),
        .trim_up (trim_up),
        .trim_dn (trim_dn),
        .done    (cal_done)
    );

    always_ff @(posedge clk) begin
        if (rst || start) begin
            dual_err <= 1'b0;
        end else if (evt.fire && evt.dual && ((|arm) || cal_arm)) begin
            dual_err <= 1'b1;
        end
    end

    assign result     = sw_p;
    assign data_ready = decided[0];

    assert_one_armed_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cal_arm, arm}));

    assert_ready_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (data_ready && !start) |=> (data_ready && $stable(result)));

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> (!data_ready && (sw_p == '0) && (sw_n == '0) && !dual_err));

    assert_ready_pair_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(data_ready) |-> (sw_p[0] || sw_n[0]));

endmodule

// File: tb/sar_bit_capture_test.sv
module sar_bit_capture_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 10;

    logic clk = 1'b0;
    logic rst, start, cmp_p, cmp_n, cal_en;
    logic [N-1:0] sw_p, sw_n, result;
    logic data_ready, trim_up, trim_dn, dual_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_bit_capture uut (
        .clk(clk), .rst(rst), .start(start), .cmp_p(cmp_p), .cmp_n(cmp_n),
        .cal_en(cal_en), .sw_p(sw_p), .sw_n(sw_n), .result(result),
        .data_ready(data_ready), .trim_up(trim_up), .trim_dn(trim_dn),
        .dual_err(dual_err)
    );

    // behavioural reference model
    int           m_count;
    logic [N-1:0] m_val;
    logic         m_pp, m_pn, m_cal_done, m_up, m_dn, m_err;

    task automatic model_clear();
        m_count = 0; m_val = '0; m_cal_done = 0; m_up = 0; m_dn = 0; m_err = 0;
    endtask

    always @(posedge clk) begin
        logic ev;
        ev = (cmp_p && !m_pp) || (cmp_n && !m_pn);
        m_up = 0; m_dn = 0;
        if (rst || start) begin
            model_clear();
        end else if (ev) begin
            if (m_count < N) begin
                m_val[N-1-m_count] = cmp_p;
                m_count++;
                if (cmp_p && cmp_n) m_err = 1;
            end else if (cal_en && !m_cal_done) begin
                m_cal_done = 1;
                m_dn = cmp_p;
                m_up = !cmp_p;
                if (cmp_p && cmp_n) m_err = 1;
            end
        end
        if (rst) begin m_pp = 0; m_pn = 0; end
        else begin m_pp = cmp_p; m_pn = cmp_n; end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d",
                     req, what, act, exp, cycles);
        end
    endtask

    function automatic logic [N-1:0] known_mask();
        logic [N-1:0] m = '0;
        for (int i = 0; i < N; i++) if (i < m_count) m[N-1-i] = 1'b1;
        return m;
    endfunction

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R4", "sw_p", 32'(sw_p), 32'(m_val & known_mask()));
            check("R3", "sw_n", 32'(sw_n), 32'(~m_val & known_mask()));
            check("R1", "result", 32'(result), 32'(m_val & known_mask()));
            check("R5", "data_ready", 32'(data_ready), 32'(m_count == N));
            check("R6", "trim_up", 32'(trim_up), 32'(m_up));
            check("R6", "trim_dn", 32'(trim_dn), 32'(m_dn));
            check("R9", "dual_err", 32'(dual_err), 32'(m_err));
        end
    end

    task automatic tick(); @(negedge clk); endtask

    // one return-to-zero decision pulse
    task automatic rz(input logic p, input logic n);
        tick(); cmp_p = p; cmp_n = n;
        tick(); cmp_p = 0; cmp_n = 0;
    endtask

    task automatic go();
        tick(); start = 1; tick(); start = 0;
    endtask

    task automatic convert(input logic [N-1:0] code);
        for (int i = N-1; i >= 0; i--) rz(code[i], !code[i]);
    endtask

    initial begin
        rst = 1; start = 0; cmp_p = 0; cmp_n = 0; cal_en = 1;
        model_clear(); m_pp = 0; m_pn = 0;
        repeat (3) tick();
        rst = 0;
        tick();
        check("R8", "ready after reset", 32'(data_ready), 0);
        check("R8", "result after reset", 32'(result), 0);

        // R1 R2 R6: conversion, then positive offset -> trim_dn
        go();
        convert(10'b1010011100);
        tick();
        check("R1", "code", 32'(result), 32'h29C);
        check("R5", "ready", 32'(data_ready), 1);
        rz(1, 0);
        rz(0, 1);   // R10 R2: ignored after cal stage done
        rz(1, 0);
        check("R10", "code held", 32'(result), 32'h29C);

        // R6: negative offset -> trim_up
        go();
        convert(10'h000);
        rz(0, 1);

        // R7: calibration off
        cal_en = 0;
        go();
        convert(10'h3FF);
        rz(1, 0);
        rz(0, 1);
        check("R7", "no trim", 32'(trim_up | trim_dn), 0);
        check("R10", "all ones held", 32'(result), 32'h3FF);
        cal_en = 1;

        // R9: both lines high at one event, and n rising while p held
        go();
        rz(1, 0); rz(0, 1);
        rz(1, 1);
        tick(); cmp_p = 1; tick(); cmp_n = 1; tick(); cmp_p = 0; cmp_n = 0;
        tick();
        check("R9", "dual flag", 32'(dual_err), 1);
        check("R9", "top bits", 32'(result[9:6]), 32'b1011);

        // R8: start mid conversion, event in the start cycle discarded
        tick(); start = 1; cmp_p = 1; tick(); start = 0; cmp_p = 0;
        tick();
        check("R8", "cleared", 32'(sw_p | sw_n), 0);
        check("R8", "dual cleared", 32'(dual_err), 0);
        convert(10'h155);
        tick();
        check("R2", "code after restart", 32'(result), 32'h155);

        // R2: held line gives no second event
        go();
        tick(); cmp_p = 1; repeat (5) tick(); cmp_p = 0;
        tick();
        check("R2", "one bit only", 32'(sw_p | sw_n), 32'h200);

        repeat (4) tick();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++; fails++;
                $display("FAIL watchdog actual=%0d expected<=20000", cycles);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

endmodule